// File: doc/BRIEF.md
# Cache-Disable Aware Write-Back Line Controller

A direct-mapped, single-level write-back data cache controller whose operating mode follows one bit of a 32-bit control register. When caching is on, CPU misses allocate. A dirty victim is written out before its slot is reused. Write hits stay in the cache as Modified. When caching is off, nothing new is allocated. A CPU access that still finds its line in the cache first pushes dirty data out and drops the line, then goes to memory as a non-cacheable access. The mode bit does not bypass the array: lines that are already resident are resolved one by one as they are touched. A flush-all command clears out whatever is left.

The block also answers coherence probes from other agents in either mode. It has a CPU port with a valid/ready request handshake and a one-cycle response pulse, a probe port, a flush command, and a memory port. Each memory request is held until memory grants it. A line holds one data word. Its index is the low `IDX_W` address bits and its tag is the rest.

Top module: `cd_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is 1 and `mem_valid` is 0, so the first read of any address goes to memory.
- R2: With caching on, a read miss fetches the word with one memory read, allocates it and returns it. A repeated read of that address is answered with no memory access.
- R3: Line states use 2 bits: Invalid 00, Shared 01, Owned 10, Modified 11. With caching on, a write hit sets Modified and changes only the cached copy. Memory keeps its old value.
- R4: With caching on, a miss whose index holds an Owned or Modified line of another tag first writes that line back to its own address. A write miss installs Modified without a memory read.
- R5: Bit 30 of `ctrl_reg` disables caching when 1. Bit 29 is sampled but never changes the mode, so with only bit 29 set, hits are served from the cache.
- R6: With caching off, a CPU read or write that hits writes the line back if it is Owned or Modified. It then invalidates the line and performs the access in memory. A later access with caching on misses.
- R7: With caching off, a miss allocates and replaces nothing, and each access goes to memory.
- R8: Every memory access made while bit 30 is set carries `mem_uc`=1, and every other access carries 0.
- R9: Probe kinds: 00 shared read, 01 exclusive read, 10 and 11 write. With caching on, a shared-read probe that hits a Modified line causes no write-back and leaves the line valid as Owned.
- R10: An exclusive-read or write probe that hits writes back an Owned or Modified line and then invalidates it. A clean line is invalidated with no memory access.
- R11: With caching off, a probe that hits an Owned or Modified line writes it back. A shared-read probe then leaves the line valid.
- R12: A pending probe is taken before a CPU request: `cpu_req_ready` is 0 while `prb_valid` is 1, and the probe's `prb_ack` comes before that request's response.
- R13: A flush pulse writes back every Owned or Modified line in increasing index order and invalidates every line. It ends with a one-cycle `flush_done` pulse.
- R14: A memory request keeps its address and direction until `mem_ready`. Each accepted CPU request gets exactly one `cpu_resp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_reg | input | 32 | Control register; bit 30 disables caching, bit 29 is ignored |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | CPU request accepted this cycle |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_resp_valid | output | 1 | One-cycle response pulse |
| cpu_rdata | output | DATA_W | Read data, valid with the response |
| prb_valid | input | 1 | Probe present |
| prb_ready | output | 1 | Probe accepted this cycle |
| prb_kind | input | 2 | Probe kind |
| prb_addr | input | ADDR_W | Probe address |
| prb_ack | output | 1 | One-cycle pulse when the probe is resolved |
| flush_req | input | 1 | Pulse requesting a flush of all lines |
| flush_done | output | 1 | One-cycle pulse when the flush is finished |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory grants the request this cycle |
| mem_we | output | 1 | 1 for a memory write |
| mem_uc | output | 1 | Access made while caching is disabled |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, taken when granted |

## Verification
The two functions that can collide are a coherence probe and a CPU request that both target the same line. The bench raises an exclusive-read probe and a CPU read of that line in the same cycle. It then checks three things: the CPU port reports not-ready in that cycle, the probe acknowledgement comes in an earlier cycle than the CPU response, and the read goes to memory, because the probe has already invalidated the line. Write-back order and `mem_uc` are judged from a memory model that logs every granted access.

// File: rtl/cd_line_ctrl.sv
module cd_line_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       ctrl_reg,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_resp_valid,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              prb_valid,
  output logic              prb_ready,
  input  logic [1:0]        prb_kind,
  input  logic [ADDR_W-1:0] prb_addr,
  output logic              prb_ack,
  input  logic              flush_req,
  output logic              flush_done,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic              mem_uc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] ST_I = 2'b00, ST_S = 2'b01, ST_O = 2'b10, ST_M = 2'b11;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_LOOK, S_CWB, S_UCA, S_EVICT, S_FILL, S_PLOOK, S_PWB, S_FLUSH
  } fsm_t;

  fsm_t              state;
  logic [1:0]        st [LINES];
  logic [TAG_W-1:0]  tg [LINES];
  logic [DATA_W-1:0] dt [LINES];
  logic              r_we, flush_pend, resp_q, ack_q, fdone_q;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata, rdata_q;
  logic [1:0]        r_kind;
  logic [IDX_W-1:0]  fidx;

  wire [IDX_W-1:0] idx    = r_addr[IDX_W-1:0];
  wire [TAG_W-1:0] tag    = r_addr[ADDR_W-1:IDX_W];
  wire             cd     = ctrl_reg[30];
  wire [1:0]       cur_st = st[idx];
  wire             hit    = (cur_st != ST_I) && (tg[idx] == tag);
  wire             dirty  = cur_st[1];
  wire             f_dirty = st[fidx][1];
  wire             p_inv  = (r_kind != 2'b00);
  wire             granted = mem_valid && mem_ready;
  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl_reg[31], ctrl_reg[29:0]};

  assign prb_ready      = (state == S_IDLE);
  assign cpu_req_ready  = (state == S_IDLE) && !prb_valid && !flush_pend;
  assign cpu_resp_valid = resp_q;
  assign cpu_rdata      = rdata_q;
  assign prb_ack        = ack_q;
  assign flush_done     = fdone_q;
  assign mem_uc         = cd;

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b1;
    mem_addr  = {tg[idx], idx};
    mem_wdata = dt[idx];
    case (state)
      S_CWB, S_EVICT, S_PWB: mem_valid = 1'b1;
      S_UCA: begin
        mem_valid = 1'b1;
        mem_we    = r_we;
        mem_addr  = r_addr;
        mem_wdata = r_wdata;
      end
      S_FILL: begin
        mem_valid = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = r_addr;
      end
      S_FLUSH: begin
        mem_valid = f_dirty;
        mem_addr  = {tg[fidx], fidx};
        mem_wdata = dt[fidx];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      r_we       <= 1'b0;
      r_addr     <= '0;
      r_wdata    <= '0;
      r_kind     <= '0;
      rdata_q    <= '0;
      fidx       <= '0;
      flush_pend <= 1'b0;
      resp_q     <= 1'b0;
      ack_q      <= 1'b0;
      fdone_q    <= 1'b0;
      for (int i = 0; i < LINES; i++) begin
        st[i] <= ST_I;
        tg[i] <= '0;
        dt[i] <= '0;
      end
    end else begin
      resp_q     <= 1'b0;
      ack_q      <= 1'b0;
      fdone_q    <= 1'b0;
      flush_pend <= flush_pend || flush_req;
      case (state)
        S_IDLE: begin
          if (prb_valid) begin
            r_addr <= prb_addr;
            r_kind <= prb_kind;
            state  <= S_PLOOK;
          end else if (flush_pend) begin
            flush_pend <= flush_req;
            fidx       <= '0;
            state      <= S_FLUSH;
          end else if (cpu_req_valid) begin
            r_addr  <= cpu_addr;
            r_we    <= cpu_we;
            r_wdata <= cpu_wdata;
            state   <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (!cd) begin
            if (hit) begin
              if (r_we) begin
                dt[idx] <= r_wdata;
                st[idx] <= ST_M;
              end else begin
                rdata_q <= dt[idx];
              end
              resp_q <= 1'b1;
              state  <= S_IDLE;
            end else if (dirty) begin
              state <= S_EVICT;
            end else if (r_we) begin
              dt[idx] <= r_wdata;
              tg[idx] <= tag;
              st[idx] <= ST_M;
              resp_q  <= 1'b1;
              state   <= S_IDLE;
            end else begin
              state <= S_FILL;
            end
          end else if (hit && dirty) begin
            state <= S_CWB;
          end else begin
            if (hit) st[idx] <= ST_I;
            state <= S_UCA;
          end
        end
        S_CWB: if (granted) begin
          st[idx] <= ST_I;
          state   <= S_UCA;
        end
        S_UCA: if (granted) begin
          if (!r_we) rdata_q <= mem_rdata;
          resp_q <= 1'b1;
          state  <= S_IDLE;
        end
        S_EVICT: if (granted) begin
          if (r_we) begin
            dt[idx] <= r_wdata;
            tg[idx] <= tag;
            st[idx] <= ST_M;
            resp_q  <= 1'b1;
            state   <= S_IDLE;
          end else begin
            st[idx] <= ST_I;
            state   <= S_FILL;
          end
        end
        S_FILL: if (granted) begin
          dt[idx] <= mem_rdata;
          tg[idx] <= tag;
          st[idx] <= ST_S;
          rdata_q <= mem_rdata;
          resp_q  <= 1'b1;
          state   <= S_IDLE;
        end
        S_PLOOK: begin
          if (hit && dirty && (cd || p_inv)) begin
            state <= S_PWB;
          end else begin
            if (hit && p_inv) st[idx] <= ST_I;
            else if (hit && !cd && cur_st == ST_M) st[idx] <= ST_O;
            ack_q <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_PWB: if (granted) begin
          st[idx] <= p_inv ? ST_I : ST_S;
          ack_q   <= 1'b1;
          state   <= S_IDLE;
        end
        S_FLUSH: if (!f_dirty || granted) begin
          st[fidx] <= ST_I;
          if (fidx == LAST) begin
            fdone_q <= 1'b1;
            state   <= S_IDLE;
          end else begin
            fidx <= fidx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cd_line_ctrl_chk.sv
module cd_line_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prb_valid,
  input logic              cpu_req_ready,
  input logic              cpu_resp_valid,
  input logic              prb_ack,
  input logic              flush_done,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  // R12
  prb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prb_valid |-> !cpu_req_ready);

  // R12
  ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prb_ack |-> !cpu_resp_valid);

  // R14
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  // R14
  one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_resp_valid |=> !cpu_resp_valid);

  // R13
  fdone_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);
endmodule

bind cd_line_ctrl cd_line_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .prb_valid(prb_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_resp_valid(cpu_resp_valid), .prb_ack(prb_ack), .flush_done(flush_done),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/tb_cd_line_ctrl.sv
module tb_cd_line_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 2;
  localparam logic [31:0] CD = 32'h4000_0000;
  localparam logic [31:0] NW = 32'h2000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] ctrl_reg = '0;
  logic cpu_req_valid = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0, prb_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic prb_valid = 1'b0, flush_req = 1'b0;
  logic [1:0] prb_kind = '0;
  logic cpu_req_ready, cpu_resp_valid, prb_ready, prb_ack, flush_done;
  logic [DATA_W-1:0] cpu_rdata, mem_wdata, mem_rdata;
  logic mem_valid, mem_we, mem_uc, mem_ready;
  logic [ADDR_W-1:0] mem_addr;

  int total = 0, bad = 0, cyc = 0;
  int rd_cnt, wr_cnt, uc_err, resp_cyc, ack_cyc;
  logic [DATA_W-1:0] memarr [256];
  logic [ADDR_W-1:0] wlog [$];
  logic [DATA_W-1:0] exp_q [$];
  bit chk_q [$];

  cd_line_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_reg(ctrl_reg),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_resp_valid(cpu_resp_valid),
    .cpu_rdata(cpu_rdata), .prb_valid(prb_valid), .prb_ready(prb_ready),
    .prb_kind(prb_kind), .prb_addr(prb_addr), .prb_ack(prb_ack),
    .flush_req(flush_req), .flush_done(flush_done), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_uc(mem_uc), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign mem_rdata = memarr[mem_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ready <= 1'b0;
      rd_cnt <= 0; wr_cnt <= 0; uc_err <= 0;
      for (int i = 0; i < 256; i++) memarr[i] <= 32'hA000_0000 | i;
    end else begin
      mem_ready <= mem_valid && !mem_ready;
      if (mem_valid && mem_ready) begin
        if (mem_uc !== ctrl_reg[30]) uc_err <= uc_err + 1;
        if (mem_we) begin
          wr_cnt <= wr_cnt + 1;
          memarr[mem_addr] <= mem_wdata;
          wlog.push_back(mem_addr);
        end else begin
          rd_cnt <= rd_cnt + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R14: one response per request, compared in order
  always @(negedge clk) begin
    if (rst_n && cpu_resp_valid) begin
      resp_cyc = cyc;
      if (exp_q.size() == 0) begin
        check(1'b0, "R14 unexpected response", cpu_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        bit c;
        e = exp_q.pop_front();
        c = chk_q.pop_front();
        if (c) check(cpu_rdata === e, "R2 read data", cpu_rdata, e);
      end
    end
  end

  always @(negedge clk) if (prb_ack) ack_cyc = cyc;

  task automatic cpu_op(input bit we, input logic [7:0] a, input logic [31:0] d, input logic [31:0] e);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    exp_q.push_back(e); chk_q.push_back(!we);
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic probe(input logic [1:0] k, input logic [7:0] a);
    @(negedge clk);
    prb_valid = 1'b1; prb_kind = k; prb_addr = a;
    while (!prb_ready) @(negedge clk);
    @(negedge clk);
    prb_valid = 1'b0;
    while (!prb_ack) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "R14 watchdog", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r0, w0, n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_req_ready === 1'b1, "R1 ready after reset", 32'(cpu_req_ready), 32'h1);
    check(mem_valid === 1'b0, "R1 mem idle after reset", 32'(mem_valid), 32'h0);

    r0 = rd_cnt; cpu_op(1'b0, 8'h04, 0, 32'hA000_0004);
    check(rd_cnt - r0 == 1, "R1 R2 first read misses", rd_cnt - r0, 1);
    r0 = rd_cnt; cpu_op(1'b0, 8'h04, 0, 32'hA000_0004);
    check(rd_cnt - r0 == 0, "R2 repeat read hits", rd_cnt - r0, 0);

    r0 = rd_cnt; cpu_op(1'b1, 8'h04, 32'h1111_1111, 0);
    check(memarr[4] == 32'hA000_0004, "R3 write hit stays in cache", memarr[4], 32'hA000_0004);
    cpu_op(1'b0, 8'h04, 0, 32'h1111_1111);
    check(rd_cnt - r0 == 0, "R3 read after write hit", rd_cnt - r0, 0);

    w0 = wr_cnt; cpu_op(1'b0, 8'h08, 0, 32'hA000_0008);
    check(memarr[4] == 32'h1111_1111, "R4 victim written back", memarr[4], 32'h1111_1111);
    check(wr_cnt - w0 == 1, "R4 one write-back", wr_cnt - w0, 1);

    ctrl_reg = NW;
    r0 = rd_cnt; w0 = wr_cnt; cpu_op(1'b0, 8'h08, 0, 32'hA000_0008);
    check(rd_cnt - r0 + wr_cnt - w0 == 0, "R5 bit29 keeps caching", rd_cnt - r0 + wr_cnt - w0, 0);

    ctrl_reg = 0; cpu_op(1'b1, 8'h08, 32'h2222_2222, 0);
    ctrl_reg = CD;
    r0 = rd_cnt; w0 = wr_cnt; cpu_op(1'b0, 8'h08, 0, 32'h2222_2222);
    check(memarr[8] == 32'h2222_2222, "R6 dirty hit written back", memarr[8], 32'h2222_2222);
    check(wr_cnt - w0 == 1 && rd_cnt - r0 == 1, "R6 write-back then uncached read", (wr_cnt - w0) * 16 + rd_cnt - r0, 32'h11);
    ctrl_reg = 0; r0 = rd_cnt; cpu_op(1'b0, 8'h08, 0, 32'h2222_2222);
    check(rd_cnt - r0 == 1, "R6 hit line invalidated", rd_cnt - r0, 1);

    ctrl_reg = CD; w0 = wr_cnt; cpu_op(1'b1, 8'h08, 32'h3333_3333, 0);
    check(wr_cnt - w0 == 1 && memarr[8] == 32'h3333_3333, "R6 clean hit write goes to memory", memarr[8], 32'h3333_3333);
    ctrl_reg = 0; r0 = rd_cnt; cpu_op(1'b0, 8'h08, 0, 32'h3333_3333);
    check(rd_cnt - r0 == 1, "R6 clean hit invalidated", rd_cnt - r0, 1);

    ctrl_reg = CD | NW;
    r0 = rd_cnt; cpu_op(1'b0, 8'h0D, 0, 32'hA000_000D); cpu_op(1'b0, 8'h0D, 0, 32'hA000_000D);
    check(rd_cnt - r0 == 2, "R7 disabled miss not allocated", rd_cnt - r0, 2);
    ctrl_reg = 0; r0 = rd_cnt; cpu_op(1'b0, 8'h0D, 0, 32'hA000_000D);
    check(rd_cnt - r0 == 1, "R7 no line left behind", rd_cnt - r0, 1);

    cpu_op(1'b1, 8'h0D, 32'h4444_4444, 0);
    w0 = wr_cnt; probe(2'b00, 8'h0D);
    check(wr_cnt - w0 == 0, "R9 shared probe no write-back", wr_cnt - w0, 0);
    r0 = rd_cnt; cpu_op(1'b0, 8'h0D, 0, 32'h4444_4444);
    check(rd_cnt - r0 == 0, "R9 line still valid", rd_cnt - r0, 0);

    w0 = wr_cnt; probe(2'b01, 8'h0D);
    check(wr_cnt - w0 == 1 && memarr[13] == 32'h4444_4444, "R10 exclusive probe writes back", memarr[13], 32'h4444_4444);
    r0 = rd_cnt; cpu_op(1'b0, 8'h0D, 0, 32'h4444_4444);
    check(rd_cnt - r0 == 1, "R10 probe invalidated", rd_cnt - r0, 1);
    w0 = wr_cnt; probe(2'b10, 8'h0D);
    check(wr_cnt - w0 == 0, "R10 clean write probe no access", wr_cnt - w0, 0);
    r0 = rd_cnt; cpu_op(1'b0, 8'h0D, 0, 32'h4444_4444);
    check(rd_cnt - r0 == 1, "R10 clean line invalidated", rd_cnt - r0, 1);

    r0 = rd_cnt; cpu_op(1'b1, 8'h0E, 32'h5555_5555, 0);
    check(rd_cnt - r0 == 0, "R4 write miss no fill", rd_cnt - r0, 0);
    ctrl_reg = CD; w0 = wr_cnt; probe(2'b00, 8'h0E);
    check(wr_cnt - w0 == 1 && memarr[14] == 32'h5555_5555, "R11 disabled probe writes back", memarr[14], 32'h5555_5555);
    ctrl_reg = 0; r0 = rd_cnt; cpu_op(1'b0, 8'h0E, 0, 32'h5555_5555);
    check(rd_cnt - r0 == 0, "R11 shared probe keeps line", rd_cnt - r0, 0);

    // R12: probe and CPU request in the same cycle on the same line
    @(negedge clk);
    r0 = rd_cnt;
    prb_valid = 1'b1; prb_kind = 2'b01; prb_addr = 8'h0E;
    cpu_req_valid = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h0E;
    exp_q.push_back(32'h5555_5555); chk_q.push_back(1'b1);
    #1;
    check(cpu_req_ready === 1'b0, "R12 cpu held off by probe", 32'(cpu_req_ready), 0);
    @(negedge clk); prb_valid = 1'b0;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk); cpu_req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check(ack_cyc < resp_cyc, "R12 probe acknowledged first", ack_cyc, resp_cyc);
    check(rd_cnt - r0 == 1, "R12 read misses after probe", rd_cnt - r0, 1);

    cpu_op(1'b1, 8'h11, 32'h6666_6666, 0);
    cpu_op(1'b1, 8'h13, 32'h7777_7777, 0);
    n0 = wlog.size();
    @(negedge clk); flush_req = 1'b1;
    @(negedge clk); flush_req = 1'b0;
    while (!flush_done) @(negedge clk);
    @(negedge clk);
    check(wlog.size() - n0 == 2, "R13 flush write-back count", wlog.size() - n0, 2);
    if (wlog.size() - n0 == 2)
      check(wlog[n0] == 8'h11 && wlog[n0+1] == 8'h13, "R13 flush index order", {wlog[n0], wlog[n0+1]}, 16'h1113);
    check(memarr[17] == 32'h6666_6666 && memarr[19] == 32'h7777_7777, "R13 flush data", memarr[19], 32'h7777_7777);
    r0 = rd_cnt; cpu_op(1'b0, 8'h08, 0, 32'h3333_3333);
    check(rd_cnt - r0 == 1, "R13 lines invalidated", rd_cnt - r0, 1);

    check(uc_err == 0, "R8 uncached flag", uc_err, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule